// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 32-bit core fetches next. It holds the program counter in a register and, each cycle, looks at the current instruction word together with the two source operand values to work out the following address. It handles the absolute region jumps, the jumps through a register, and every conditional branch. These include the register-to-register equality tests and the sign tests of a single operand against zero.

Beside the next address, the block raises a taken flag. For the linking jumps it also requests a register write of the return address, which is the current PC plus 8, and gives the destination index. A register jump to an address that is not word aligned is refused: an error flag rises, and the PC keeps its value. The PC register loads the computed address only while the enable input is high.

Top module: `npc_resolver`

## Requirements
- R1: On a synchronous active-high reset the PC register takes the value of parameter RESET_VEC.
- R2: An instruction that is not a control transfer gives next_pc = PC+4, taken low, link_we low and addr_err low.
- R3: Opcode 000010 (bits 31:26) gives next_pc = {PC[31:28], instr[25:0], 2'b00} with taken high and no link write.
- R4: Opcode 000011 makes the same jump as R3 and requests link_we with link_idx 31 and link_data = PC+8.
- R5: Opcode 000000 with funct 001000 (bits 5:0) and zero in bits 20:6 gives next_pc = rs_val, taken high and no link write.
- R6: Opcode 000000 with funct 001001, zero in bits 20:16 and zero in bits 10:6 gives next_pc = rs_val and requests a link write of PC+8 to the index in bits 15:11.
- R7: When the jump of R5 or R6 targets an address with nonzero bits 1:0, addr_err is high, next_pc equals the current PC, taken and link_we are low, and an enabled clock edge leaves the PC unchanged.
- R8: Opcode 000100 is taken when rs_val equals rt_val, and opcode 000101 when they differ. A taken branch goes to PC+4 plus the sign-extended bits 15:0 shifted left by 2. A branch that is not taken goes to PC+4.
- R9: Opcode 000110 with bits 20:16 zero is taken when rs_val, read as signed, is at most zero. Opcode 000111 with bits 20:16 zero is taken when rs_val is above zero.
- R10: Opcode 000001 is taken when rs_val is negative if bits 20:16 are 00000, and when rs_val is non-negative if they are 00001. Any other value of bits 20:16 is not a control transfer.
- R11: The PC register loads next_pc on a clock edge with pc_en high, and holds its value with pc_en low.
- R12: A register jump or zero-compare branch whose fields that must be zero are not zero is treated as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_en | input | 1 | PC register load enable |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc_q | output | 32 | Registered current PC |
| next_pc | output | 32 | Computed next PC |
| taken | output | 1 | Control transfer redirects the flow |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Destination register of the return address |
| link_data | output | 32 | Return address, PC+8 |
| addr_err | output | 1 | Misaligned register-jump target |

## Verification
The bench goes after the sign boundaries of the zero compares, using rs_val values of zero, one and 0x80000000. A design that compares unsigned, or swaps strict and non-strict, takes the wrong path at exactly those points. A branch offset of all ones must land back on the PC itself, so a missing sign extension shows up as a far-off target. The region jump runs from a PC with nonzero top bits and a target field of all ones, which exposes a wrong concatenation. Misaligned register jumps are checked to freeze the PC and to drop the link write. Malformed encodings and an unknown opcode-000001 rt value must fall through to PC+4, not take.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_JABS = 2'd1,
    XFER_JREG = 2'd2,
    XFER_BR   = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LEZ = 3'd2,
    CMP_GTZ = 3'd3,
    CMP_LTZ = 3'd4,
    CMP_GEZ = 3'd5
  } cmp_sel_e;

  typedef struct packed {
    xfer_kind_e kind;
    cmp_sel_e   cmp;
    logic       link;
    logic [4:0] link_idx;
  } xfer_dec_t;

  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_JMP     = 6'b000010;
  localparam logic [5:0] OP_JMPLNK  = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [5:0] OP_BLEZ    = 6'b000110;
  localparam logic [5:0] OP_BGTZ    = 6'b000111;
  localparam logic [5:0] FN_JREG    = 6'b001000;
  localparam logic [5:0] FN_JREGLNK = 6'b001001;
  localparam logic [4:0] RT_LTZ     = 5'b00000;
  localparam logic [4:0] RT_GEZ     = 5'b00001;
  localparam logic [4:0] RET_REG    = 5'd31;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] rt_f,
  input  logic [4:0] rd_f,
  input  logic [4:0] sa_f,
  input  logic [5:0] funct,
  output xfer_dec_t  dec
);

  always_comb begin
    dec          = '0;
    dec.kind     = XFER_NONE;
    dec.cmp      = CMP_EQ;
    dec.link     = 1'b0;
    dec.link_idx = '0;
    unique case (opcode)
      OP_JMP: dec.kind = XFER_JABS;
      OP_JMPLNK: begin
        dec.kind     = XFER_JABS;
        dec.link     = 1'b1;
        dec.link_idx = RET_REG;
      end
      OP_SPECIAL: begin
        if (funct == FN_JREG && rt_f == '0 && rd_f == '0 && sa_f == '0) begin
          dec.kind = XFER_JREG;
        end else if (funct == FN_JREGLNK && rt_f == '0 && sa_f == '0) begin
          dec.kind     = XFER_JREG;
          dec.link     = 1'b1;
          dec.link_idx = rd_f;
        end
      end
      OP_BEQ: begin
        dec.kind = XFER_BR;
        dec.cmp  = CMP_EQ;
      end
      OP_BNE: begin
        dec.kind = XFER_BR;
        dec.cmp  = CMP_NE;
      end
      OP_BLEZ: begin
        if (rt_f == '0) begin
          dec.kind = XFER_BR;
          dec.cmp  = CMP_LEZ;
        end
      end
      OP_BGTZ: begin
        if (rt_f == '0) begin
          dec.kind = XFER_BR;
          dec.cmp  = CMP_GTZ;
        end
      end
      OP_REGIMM: begin
        if (rt_f == RT_LTZ) begin
          dec.kind = XFER_BR;
          dec.cmp  = CMP_LTZ;
        end else if (rt_f == RT_GEZ) begin
          dec.kind = XFER_BR;
          dec.cmp  = CMP_GEZ;
        end
      end
      default: dec.kind = XFER_NONE;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cmp_sel_e          cmp,
  input  logic [XLEN-1:0]   a_val,
  input  logic [XLEN-1:0]   b_val,
  output logic              hit
);

  logic is_eq;
  logic is_neg;
  logic is_zero;

  assign is_eq   = (a_val == b_val);
  assign is_neg  = a_val[XLEN-1];
  assign is_zero = (a_val == '0);

  always_comb begin
    unique case (cmp)
      CMP_EQ:  hit = is_eq;
      CMP_NE:  hit = !is_eq;
      CMP_LEZ: hit = is_neg || is_zero;
      CMP_GTZ: hit = !is_neg && !is_zero;
      CMP_LTZ: hit = is_neg;
      CMP_GEZ: hit = !is_neg;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REGION_W = 4,
  parameter int ALIGN_W  = 2,
  parameter int IMM_W    = 16
) (
  input  logic [XLEN-1:0]                  pc,
  input  logic [XLEN-REGION_W-ALIGN_W-1:0] jfield,
  input  logic [IMM_W-1:0]                 imm,
  input  logic [XLEN-1:0]                  reg_tgt,
  input  xfer_dec_t                        dec,
  input  logic                             cond_hit,
  output logic [XLEN-1:0]                  npc,
  output logic                             redirect,
  output logic                             misalign,
  output logic                             lnk_we,
  output logic [4:0]                       lnk_idx,
  output logic [XLEN-1:0]                  lnk_data
);

  localparam int              EXT_W    = XLEN - IMM_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP     = XLEN'(1 << ALIGN_W);
  localparam logic [XLEN-1:0] STEP_TWO = XLEN'(2 << ALIGN_W);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jabs_pc;
  logic            reg_bad;

  assign seq_pc  = pc + STEP;
  assign br_off  = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
  assign br_pc   = seq_pc + br_off;
  assign jabs_pc = {pc[XLEN-1 -: REGION_W], jfield, {ALIGN_W{1'b0}}};
  assign reg_bad = (reg_tgt[ALIGN_W-1:0] != '0);

  always_comb begin
    npc      = seq_pc;
    redirect = 1'b0;
    misalign = 1'b0;
    unique case (dec.kind)
      XFER_JABS: begin
        npc      = jabs_pc;
        redirect = 1'b1;
      end
      XFER_JREG: begin
        if (reg_bad) begin
          npc      = pc;
          misalign = 1'b1;
        end else begin
          npc      = reg_tgt;
          redirect = 1'b1;
        end
      end
      XFER_BR: begin
        if (cond_hit) begin
          npc      = br_pc;
          redirect = 1'b1;
        end
      end
      default: npc = seq_pc;
    endcase
  end

  assign lnk_we   = dec.link && !misalign;
  assign lnk_idx  = dec.link_idx;
  assign lnk_data = pc + STEP_TWO;

endmodule

// File: rtl/npc_resolver.sv
module npc_resolver
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              REGION_W  = 4,
  parameter int              ALIGN_W   = 2,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_en,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [4:0]      link_idx,
  output logic [XLEN-1:0] link_data,
  output logic            addr_err
);

  localparam int JF_W  = XLEN - REGION_W - ALIGN_W;
  localparam int IMM_W = 16;

  xfer_dec_t dec;
  logic      cond_hit;

  npc_decode u_dec (
    .opcode (instr[31:26]),
    .rt_f   (instr[20:16]),
    .rd_f   (instr[15:11]),
    .sa_f   (instr[10:6]),
    .funct  (instr[5:0]),
    .dec    (dec)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .cmp   (dec.cmp),
    .a_val (rs_val),
    .b_val (rt_val),
    .hit   (cond_hit)
  );

  npc_target #(
    .XLEN     (XLEN),
    .REGION_W (REGION_W),
    .ALIGN_W  (ALIGN_W),
    .IMM_W    (IMM_W)
  ) u_tgt (
    .pc       (pc_q),
    .jfield   (instr[JF_W-1:0]),
    .imm      (instr[IMM_W-1:0]),
    .reg_tgt  (rs_val),
    .dec      (dec),
    .cond_hit (cond_hit),
    .npc      (next_pc),
    .redirect (taken),
    .misalign (addr_err),
    .lnk_we   (link_we),
    .lnk_idx  (link_idx),
    .lnk_data (link_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_VEC;
    end else if (pc_en) begin
      pc_q <= next_pc;
    end
  end

endmodule

// File: rtl/npc_resolver_chk.sv
module npc_resolver_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            pc_en,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            link_we,
  input logic [XLEN-1:0] link_data,
  input logic            addr_err
);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!pc_en) |=> $stable(pc_q));

  a_r11_load: assert property (@(posedge clk) disable iff (rst)
    (pc_en) |=> (pc_q == $past(next_pc)));

  a_r7_err_freeze: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (!taken && !link_we && next_pc == pc_q));

  a_r6_link_value: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_data == pc_q + 32'd8));

  a_r2_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (!taken && !addr_err) |-> (next_pc == pc_q + 32'd4));

endmodule

bind npc_resolver npc_resolver_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc_en     (pc_en),
  .pc_q      (pc_q),
  .next_pc   (next_pc),
  .taken     (taken),
  .link_we   (link_we),
  .link_data (link_data),
  .addr_err  (addr_err)
);

// File: tb/npc_resolver_tb.sv
module npc_resolver_tb;

  localparam logic [31:0] RVEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic        pc_en;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] pc_q;
  logic [31:0] next_pc;
  logic        taken;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;
  logic        addr_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  npc_resolver #(.RESET_VEC(RVEC)) u_dut (
    .clk(clk), .rst(rst), .pc_en(pc_en), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc_q(pc_q), .next_pc(next_pc),
    .taken(taken), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .addr_err(addr_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w_jr(input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, 5'd1, 5'd0, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] w_br(input logic [5:0] op, input logic [4:0] rtf,
                                       input logic [15:0] imm);
    return {op, 5'd1, rtf, imm};
  endfunction

  task automatic drive(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr  = iw;
    rs_val = a;
    rt_val = b;
    pc_en  = 1'b0;
    #1;
  endtask

  task automatic step_pc();
    pc_en = 1'b1;
    @(posedge clk);
    #1;
    pc_en = 1'b0;
  endtask

  task automatic set_pc(input logic [31:0] v);
    drive(w_jr(5'd0, 6'b001000), v, 32'd0);
    step_pc();
  endtask

  task automatic expect_br(input string req, input logic [31:0] iw,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic tk, input logic [31:0] tgt);
    drive(iw, a, b);
    chk(req, "taken", {31'd0, taken}, {31'd0, tk});
    chk(req, "next_pc", next_pc, tgt);
  endtask

  task automatic t_reset();
    rst = 1'b1; pc_en = 1'b0; instr = '0; rs_val = '0; rt_val = '0;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R1", "pc after reset", pc_q, RVEC);
    set_pc(32'h0000_4000);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    chk("R1", "pc after second reset", pc_q, RVEC);
  endtask

  task automatic t_seq();
    drive({6'b001001, 5'd1, 5'd2, 16'h1234}, 32'h3, 32'h5);
    chk("R2", "next_pc", next_pc, RVEC + 32'd4);
    chk("R2", "taken/link/err", {29'd0, taken, link_we, addr_err}, 32'd0);
    drive({6'b000000, 5'd1, 5'd2, 5'd3, 5'd0, 6'b100001}, 32'h3, 32'h5);
    chk("R2", "alu op next_pc", next_pc, RVEC + 32'd4);
  endtask

  task automatic t_jabs();
    set_pc(32'hA000_0010);
    drive({6'b000010, 26'h3FF_FFFF}, 32'h0, 32'h0);
    chk("R3", "region jump", next_pc, 32'hAFFF_FFFC);
    chk("R3", "taken/link", {30'd0, taken, link_we}, 32'd2);
    drive({6'b000011, 26'h000_0040}, 32'h0, 32'h0);
    chk("R4", "linked jump", next_pc, 32'hA000_0100);
    chk("R4", "link_we", {31'd0, link_we}, 32'd1);
    chk("R4", "link_idx", {27'd0, link_idx}, 32'd31);
    chk("R4", "link_data", link_data, 32'hA000_0018);
  endtask

  task automatic t_jreg();
    set_pc(32'h0000_2000);
    drive(w_jr(5'd0, 6'b001000), 32'h1234_5678, 32'h0);
    chk("R5", "reg jump", next_pc, 32'h1234_5678);
    chk("R5", "taken/link", {30'd0, taken, link_we}, 32'd2);
    drive(w_jr(5'd7, 6'b001001), 32'h0000_8000, 32'h0);
    chk("R6", "reg jump link target", next_pc, 32'h0000_8000);
    chk("R6", "link_we/idx", {26'd0, link_we, link_idx}, {26'd0, 1'b1, 5'd7});
    chk("R6", "link_data", link_data, 32'h0000_2008);
  endtask

  task automatic t_misalign();
    set_pc(32'h0000_3000);
    drive(w_jr(5'd9, 6'b001001), 32'h0000_5002, 32'h0);
    chk("R7", "addr_err", {31'd0, addr_err}, 32'd1);
    chk("R7", "next_pc held", next_pc, 32'h0000_3000);
    chk("R7", "taken/link", {30'd0, taken, link_we}, 32'd0);
    step_pc();
    chk("R7", "pc after enabled edge", pc_q, 32'h0000_3000);
    drive(w_jr(5'd0, 6'b001000), 32'h0000_5001, 32'h0);
    chk("R7", "plain reg jump err", {31'd0, addr_err}, 32'd1);
  endtask

  task automatic t_eqne();
    set_pc(32'h0000_1000);
    expect_br("R8", w_br(6'b000100, 5'd2, 16'h0010), 32'h55, 32'h55, 1'b1, 32'h0000_1044);
    expect_br("R8", w_br(6'b000100, 5'd2, 16'h0010), 32'h55, 32'h56, 1'b0, 32'h0000_1004);
    expect_br("R8", w_br(6'b000101, 5'd2, 16'hFFFF), 32'h55, 32'h56, 1'b1, 32'h0000_1000);
    expect_br("R8", w_br(6'b000101, 5'd2, 16'hFFFF), 32'h7, 32'h7, 1'b0, 32'h0000_1004);
    expect_br("R8", w_br(6'b000100, 5'd2, 16'h8000), 32'h0, 32'h0, 1'b1, 32'hFFFE_1004);
  endtask

  task automatic t_zero();
    set_pc(32'h0000_1000);
    expect_br("R9", w_br(6'b000110, 5'd0, 16'h0004), 32'h0, 32'h0, 1'b1, 32'h0000_1014);
    expect_br("R9", w_br(6'b000110, 5'd0, 16'h0004), 32'h1, 32'h0, 1'b0, 32'h0000_1004);
    expect_br("R9", w_br(6'b000110, 5'd0, 16'h0004), 32'h8000_0000, 32'h0, 1'b1, 32'h0000_1014);
    expect_br("R9", w_br(6'b000111, 5'd0, 16'h0004), 32'h1, 32'h0, 1'b1, 32'h0000_1014);
    expect_br("R9", w_br(6'b000111, 5'd0, 16'h0004), 32'h0, 32'h0, 1'b0, 32'h0000_1004);
    expect_br("R9", w_br(6'b000111, 5'd0, 16'h0004), 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0000_1004);
  endtask

  task automatic t_regimm();
    set_pc(32'h0000_1000);
    expect_br("R10", w_br(6'b000001, 5'd0, 16'h0002), 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0000_100C);
    expect_br("R10", w_br(6'b000001, 5'd0, 16'h0002), 32'h0, 32'h0, 1'b0, 32'h0000_1004);
    expect_br("R10", w_br(6'b000001, 5'd1, 16'h0002), 32'h0, 32'h0, 1'b1, 32'h0000_100C);
    expect_br("R10", w_br(6'b000001, 5'd1, 16'h0002), 32'h8000_0000, 32'h0, 1'b0, 32'h0000_1004);
    expect_br("R10", w_br(6'b000001, 5'd2, 16'h0002), 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0000_1004);
  endtask

  task automatic t_malformed();
    set_pc(32'h0000_1000);
    expect_br("R12", w_br(6'b000110, 5'd3, 16'h0004), 32'h0, 32'h0, 1'b0, 32'h0000_1004);
    expect_br("R12", {6'b000000, 5'd1, 5'd0, 5'd0, 5'd4, 6'b001000},
              32'h0000_8000, 32'h0, 1'b0, 32'h0000_1004);
    chk("R12", "no link on malformed", {31'd0, link_we}, 32'd0);
  endtask

  task automatic t_enable();
    set_pc(32'h0000_6000);
    drive({6'b000010, 26'h000_0100}, 32'h0, 32'h0);
    @(posedge clk); #1;
    chk("R11", "pc held with enable low", pc_q, 32'h0000_6000);
    step_pc();
    chk("R11", "pc loaded with enable high", pc_q, 32'h0000_0400);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_jabs();
    t_jreg();
    t_misalign();
    t_eqne();
    t_zero();
    t_regimm();
    t_malformed();
    t_enable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule